// File: doc/BRIEF.md
# Multi-Operand Counter-Tree Adder

This block adds N unsigned operands of W bits each and returns their exact total. The operands are regarded as columns of bits, one column per binary weight. Column c holds bit c of every operand. Successive reduction levels then shrink the columns with small counters. Each counter reads at most six bits from one column, or from two adjacent columns, and writes a short binary count. Reduction stops once no column holds more than three bits. One three-input carry-propagate adder then forms the final sum.

The counter placement is worked out while the design elaborates, from N and W only. The structure is therefore fixed. Within a level, the tallest column is served first. Among the counter shapes that fit, the one with the best ratio of bits consumed to bits produced wins. Bits that no counter takes pass to the next level unchanged. Each count bit is routed to the column matching its weight. A parameter selects either a purely combinational result or one output register with a matching valid flag.

Top module: `gpc_sum_tree`

## Requirements
- R1: `sum` equals the arithmetic total of all N operands and is W + ceil(log2 N) bits wide. This holds for every operand pattern, including all operands at their maximum value.
- R2: Every reduction level preserves the weighted value of the bits that enter it. The total stays exact when the operand count needs several levels (N = 8, N = 13).
- R3: The last level hands at most three bits per column to the final adder. When N is three or fewer, no reduction level exists and the operands go straight to that adder.
- R4: With OUT_REG = 1, `sum` and `out_valid` appear one clock after the operands and `in_valid` are presented. `out_valid` is the value `in_valid` had one cycle earlier.
- R5: With OUT_REG = 1, a clock edge with `in_valid` low leaves `sum` unchanged, whatever the operands are.
- R6: With OUT_REG = 1, a clock edge with `rst_n` low clears `sum` to 0 and `out_valid` to 0, even while `in_valid` is high.
- R7: With OUT_REG = 0, `sum` follows the operands with no clock, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the operands as a request to be summed |
| operands | input | N*W | N packed operands, operand k in bits [k*W +: W] |
| out_valid | output | 1 | Marks `sum` as holding a fresh result |
| sum | output | W+ceil(log2 N) | Exact total of the operands |

## Verification
The bench goes after the cases where a reduction schedule typically breaks. All-ones operands fill every column and the top output bit. If the routing drops a carry bit from a counter that spans two ranks, the bench sees a total that is short by a power of two. Single-bit-per-operand patterns, such as a walking one, stress bits left unserved by counters. A fault in the pass-through path shows up as a missing weight in those totals. The N = 3 build has no reduction level at all. The N = 13 build needs several levels with uneven column heights. In registered mode, an off-by-one in latency, a register that loads while `in_valid` is low, or a reset that loses to `in_valid` each shows up as a stale or early value on `sum`.

// File: rtl/gpc_pkg.sv
// Package gpc_pkg
// Elaboration-time planner for the counter tree. Column heights travel as
// packed vectors of 8-bit counts. A level's counter list travels as packed
// 16-bit entries {rank, bits from rank+1, bits from rank}. An entry whose
// rank-bit count is zero ends the list.
// Assumes at most 64 columns, 255 bits per column and 256 counters per level.
package gpc_pkg;

    localparam int MAXCOL = 64;
    localparam int MAXC   = 256;
    localparam int MAXSTG = 32;
    localparam int HVW    = MAXCOL * 8;
    localparam int CLW    = MAXC * 16;

    typedef logic [HVW-1:0] hvec_t;
    typedef logic [CLW-1:0] clist_t;

    // Number of result bits a counter needs for its largest possible count.
    function automatic int out_bits(input int k0, input int k1);
        int m;
        int b;
        m = k0 + 2 * k1;
        b = 0;
        while ((1 << b) <= m) b++;
        return b;
    endfunction

    // Width of the final sum.
    function automatic int sum_width(input int n, input int w);
        return w + $clog2(n);
    endfunction

    // Pick the best six-input shape for a column of height h0 beside one of
    // height h1. The result is {k1, k0}, or 0 when no shape reduces bits.
    function automatic logic [7:0] pick_shape(input int h0, input int h1);
        int bk0, bk1, bin, bout, k0, k1, nin, ob;
        bk0 = 0; bk1 = 0; bin = 0; bout = 1;
        for (int t = 0; t < 4; t++) begin
            k0 = (h0 < 6 - t) ? h0 : 6 - t;
            k1 = (h1 < t) ? h1 : t;
            if (k0 >= 2) begin
                nin = k0 + k1;
                ob  = out_bits(k0, k1);
                if (nin > ob && nin * bout > bin * ob) begin
                    bk0 = k0; bk1 = k1; bin = nin; bout = ob;
                end
            end
        end
        return (bin == 0) ? 8'd0 : 8'(bk1 * 16 + bk0);
    endfunction

    // Greedy allocation for one level. The tallest open column (lowest rank
    // on a tie) is served first.
    function automatic clist_t plan_alloc(input hvec_t hv, input int cols);
        int     rem [MAXCOL];
        bit     done [MAXCOL];
        clist_t cl;
        int     nc, best, bh, k0, k1;
        bit     stop;
        logic [7:0] shp;
        cl = '0; nc = 0; stop = 1'b0;
        for (int c = 0; c < MAXCOL; c++) begin
            rem[c]  = (c < cols) ? int'(hv[c*8 +: 8]) : 0;
            done[c] = 1'b0;
        end
        for (int it = 0; it < MAXC + MAXCOL; it++) begin
            if (!stop) begin
                best = -1; bh = 1;
                for (int c = 0; c < cols; c++) begin
                    if (!done[c] && rem[c] > bh) begin
                        bh = rem[c]; best = c;
                    end
                end
                if (best < 0) begin
                    stop = 1'b1;
                end else begin
                    shp = pick_shape(rem[best], (best + 1 < cols) ? rem[best+1] : 0);
                    if (shp == 8'd0) begin
                        done[best] = 1'b1;
                    end else if (nc < MAXC) begin
                        k0 = int'(shp[3:0]);
                        k1 = int'(shp[7:4]);
                        rem[best] = rem[best] - k0;
                        if (k1 > 0) rem[best+1] = rem[best+1] - k1;
                        cl[nc*16 +: 16] = {8'(best), 4'(k1), 4'(k0)};
                        nc++;
                    end else begin
                        stop = 1'b1;
                    end
                end
            end
        end
        return cl;
    endfunction

    // Number of counters in a list.
    function automatic int count_counters(input clist_t cl);
        int n;
        n = 0;
        for (int i = 0; i < MAXC; i++)
            if (cl[i*16 +: 4] != 4'd0) n++;
        return n;
    endfunction

    // Column heights after one level: unused bits plus rank-aligned outputs.
    function automatic hvec_t plan_next(input hvec_t hv, input clist_t cl, input int cols);
        int    nh [MAXCOL];
        hvec_t res;
        int    r, k0, k1, ob;
        res = '0;
        for (int c = 0; c < MAXCOL; c++) nh[c] = (c < cols) ? int'(hv[c*8 +: 8]) : 0;
        for (int i = 0; i < MAXC; i++) begin
            k0 = int'(cl[i*16 +: 4]);
            k1 = int'(cl[i*16+4 +: 4]);
            r  = int'(cl[i*16+8 +: 8]);
            if (k0 > 0) begin
                nh[r] = nh[r] - k0;
                if (k1 > 0) nh[r+1] = nh[r+1] - k1;
                ob = out_bits(k0, k1);
                for (int j = 0; j < 4; j++)
                    if (j < ob && r + j < cols) nh[r+j] = nh[r+j] + 1;
            end
        end
        for (int c = 0; c < cols; c++) res[c*8 +: 8] = 8'(nh[c]);
        return res;
    endfunction

    // Tallest column of a height vector.
    function automatic int max_of(input hvec_t hv);
        int m;
        m = 0;
        for (int c = 0; c < MAXCOL; c++)
            if (int'(hv[c*8 +: 8]) > m) m = int'(hv[c*8 +: 8]);
        return m;
    endfunction

    // Heights seen at the input of level s.
    function automatic hvec_t stage_heights(input int n, input int w, input int s);
        hvec_t hv;
        int    cols;
        cols = sum_width(n, w);
        hv = '0;
        for (int c = 0; c < w; c++) hv[c*8 +: 8] = 8'(n);
        for (int k = 0; k < MAXSTG; k++)
            if (k < s) hv = plan_next(hv, plan_alloc(hv, cols), cols);
        return hv;
    endfunction

    // Levels needed until no column exceeds three bits.
    function automatic int num_stages(input int n, input int w);
        hvec_t hv;
        int    cols, cnt;
        cols = sum_width(n, w);
        hv = stage_heights(n, w, 0);
        cnt = 0;
        for (int k = 0; k < MAXSTG; k++) begin
            if (max_of(hv) > 3) begin
                hv = plan_next(hv, plan_alloc(hv, cols), cols);
                cnt++;
            end
        end
        return cnt;
    endfunction

    // Storage depth per column that covers every level, at least three.
    function automatic int peak_height(input int n, input int w);
        int m, ns;
        ns = num_stages(n, w);
        m = 3;
        for (int s = 0; s <= MAXSTG; s++)
            if (s <= ns && max_of(stage_heights(n, w, s)) > m)
                m = max_of(stage_heights(n, w, s));
        return m;
    endfunction

endpackage

// File: rtl/gpc_stage.sv
// Module gpc_stage
// One reduction level. It applies the planned counters to the bit columns it
// receives. Bits no counter takes pass straight through. Each counter's
// result bit j lands in column rank+j.
// Assumes bits above a column's planned height are zero, and that col_in is
// laid out [column][slot].
module gpc_stage #(
    parameter int N = 8,
    parameter int W = 8,
    parameter int S = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [gpc_pkg::sum_width(N, W)-1:0][gpc_pkg::peak_height(N, W)-1:0] col_in,
    output logic [gpc_pkg::sum_width(N, W)-1:0][gpc_pkg::peak_height(N, W)-1:0] col_out
);
    localparam int COLS = gpc_pkg::sum_width(N, W);
    localparam int HMAX = gpc_pkg::peak_height(N, W);
    localparam gpc_pkg::hvec_t  HV_IN = gpc_pkg::stage_heights(N, W, S);
    localparam gpc_pkg::clist_t CL    = gpc_pkg::plan_alloc(HV_IN, COLS);
    localparam int NC  = gpc_pkg::count_counters(CL);
    localparam int NCS = (NC > 0) ? NC : 1;

    typedef logic [COLS-1:0][HMAX-1:0] cols_t;

    // Apply counters from the top of each column, then route unused bits and count bits.
    always_comb begin : reduce_p
        int rem  [COLS];
        int fill [COLS];
        logic [3:0] cval [NCS];
        int r, k0, k1, ob, acc;
        col_out = '0;
        for (int i = 0; i < NCS; i++) cval[i] = '0;
        for (int c = 0; c < COLS; c++) rem[c] = int'(HV_IN[c*8 +: 8]);
        for (int i = 0; i < NC; i++) begin
            k0 = int'(CL[i*16 +: 4]);
            k1 = int'(CL[i*16+4 +: 4]);
            r  = int'(CL[i*16+8 +: 8]);
            acc = 0;
            for (int j = 0; j < 6; j++)
                if (j < k0) acc = acc + int'(col_in[r][rem[r]-1-j]);
            if (r + 1 < COLS) begin
                for (int j = 0; j < 3; j++)
                    if (j < k1) acc = acc + 2 * int'(col_in[r+1][rem[r+1]-1-j]);
                rem[r+1] = rem[r+1] - k1;
            end
            rem[r] = rem[r] - k0;
            cval[i] = 4'(acc);
        end
        for (int c = 0; c < COLS; c++) begin
            for (int k = 0; k < HMAX; k++)
                if (k < rem[c]) col_out[c][k] = col_in[c][k];
            fill[c] = rem[c];
        end
        for (int i = 0; i < NC; i++) begin
            k0 = int'(CL[i*16 +: 4]);
            k1 = int'(CL[i*16+4 +: 4]);
            r  = int'(CL[i*16+8 +: 8]);
            ob = gpc_pkg::out_bits(k0, k1);
            for (int j = 0; j < 4; j++) begin
                if (j < ob && r + j < COLS) begin
                    if (fill[r+j] < HMAX) col_out[r+j][fill[r+j]] = cval[i][j];
                    fill[r+j] = fill[r+j] + 1;
                end
            end
        end
    end

    // Weighted value of a set of columns, modulo the sum width.
    function automatic logic [COLS-1:0] weigh(input cols_t b);
        logic [COLS-1:0] t;
        t = '0;
        for (int c = 0; c < COLS; c++)
            for (int k = 0; k < HMAX; k++)
                if (b[c][k]) t = t + ({{(COLS-1){1'b0}}, 1'b1} << c);
        return t;
    endfunction

    // The level must not change the value it carries.
    assert_stage_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        weigh(col_out) == weigh(col_in))
        else $error("reduction level %0d altered the weighted total", S);

endmodule

// File: rtl/gpc_ternary_add.sv
// Module gpc_ternary_add
// Final carry-propagate adder. It sums the three rows left by the last level.
// Assumes each column offers slots [2:0] and that any slot beyond a column's
// height is zero. Bits of weight above the sum width are always zero and are
// not used.
module gpc_ternary_add #(
    parameter int OW = 11
) (
    input  logic [OW-1:0][2:0] rows,
    output logic [OW-1:0]      total
);
    logic [OW-1:0] row_a, row_b, row_c;

    // Split the column slots into three operand rows.
    always_comb begin : split_p
        for (int c = 0; c < OW; c++) begin
            row_a[c] = rows[c][0];
            row_b[c] = rows[c][1];
            row_c[c] = rows[c][2];
        end
    end

    // One three-input addition, truncated to the width that cannot overflow.
    always_comb begin : add_p
        total = row_a + row_b + row_c;
    end

endmodule

// File: rtl/gpc_sum_tree.sv
// Module gpc_sum_tree
// Top of the multi-operand adder. It spreads the operands into columns,
// chains the planned reduction levels, finishes with the ternary adder and
// can register the result.
// Assumes unsigned operands, and N and W small enough for the planner limits
// (sum width <= 64, N <= 255).
module gpc_sum_tree #(
    parameter int N       = 8,
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int OW     = W + $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [N-1:0][W-1:0] operands,
    output logic                out_valid,
    output logic [OW-1:0]       sum
);
    localparam int NS   = gpc_pkg::num_stages(N, W);
    localparam int HMAX = gpc_pkg::peak_height(N, W);

    typedef logic [OW-1:0][HMAX-1:0] cols_t;

    cols_t                lvl0;
    cols_t                fin;
    logic [OW-1:0][2:0]   fin3;
    logic [OW-1:0]        tree_sum;

    // Column c, slot k carries bit c of operand k.
    always_comb begin : spread_p
        lvl0 = '0;
        for (int c = 0; c < W; c++)
            for (int k = 0; k < N; k++)
                lvl0[c][k] = operands[k][c];
    end

    for (genvar s = 0; s < NS; s++) begin : g_stg
        cols_t cin;
        cols_t cout;
        if (s == 0) begin : g_first
            assign cin = lvl0;
        end else begin : g_chain
            assign cin = g_stg[s-1].cout;
        end
        gpc_stage #(.N(N), .W(W), .S(s)) u_stg (
            .clk     (clk),
            .rst_n   (rst_n),
            .col_in  (cin),
            .col_out (cout)
        );
    end

    if (NS == 0) begin : g_direct
        assign fin = lvl0;
    end else begin : g_reduced
        assign fin = g_stg[NS-1].cout;
    end

    // Keep the three lowest slots of every column for the final adder.
    always_comb begin : rows_p
        for (int c = 0; c < OW; c++) fin3[c] = fin[c][2:0];
    end

    gpc_ternary_add #(.OW(OW)) u_cpa (
        .rows  (fin3),
        .total (tree_sum)
    );

    // Reference total used only by the checks below.
    function automatic logic [OW-1:0] ref_total(input logic [N-1:0][W-1:0] ops);
        logic [OW-1:0] t;
        t = '0;
        for (int k = 0; k < N; k++) t = t + OW'(ops[k]);
        return t;
    endfunction

    if (OUT_REG) begin : g_reg
        // Load the result on a valid request, clear both outputs on reset.
        always_ff @(posedge clk) begin : out_reg_p
            if (!rst_n) begin
                sum       <= '0;
                out_valid <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) sum <= tree_sum;
            end
        end

        assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_valid && sum == $past(ref_total(operands))))
            else $error("registered result missing one cycle after request");
        assert_valid_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid)
            else $error("out_valid raised without a request");
        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(sum))
            else $error("sum changed while no request was present");
        assert_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (!out_valid && sum == '0))
            else $error("outputs not cleared by reset");
    end else begin : g_comb
        assign sum       = tree_sum;
        assign out_valid = in_valid;
    end

    // The tree total must match the operands in every clocked cycle.
    assert_tree_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tree_sum == ref_total(operands))
        else $error("tree total differs from operand total");

    if (HMAX > 3) begin : g_rows_chk
        logic excess;
        // Any bit above slot 2 in the last level would be lost by the adder.
        always_comb begin : excess_p
            excess = 1'b0;
            for (int c = 0; c < OW; c++) excess = excess | (|fin[c][HMAX-1:3]);
        end
        assert_three_rows_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !excess)
            else $error("final level holds more than three bits in a column");
    end

endmodule

// File: tb/sim_gpc_sum_tree.sv
module sim_gpc_sum_tree;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // u0: N=8, W=8, registered
    logic             v0 = 1'b0;
    logic [7:0][7:0]  op0 = '0;
    logic             ov0;
    logic [10:0]      s0;
    // u1: N=3, W=6, combinational
    logic             v1 = 1'b0;
    logic [2:0][5:0]  op1 = '0;
    logic             ov1;
    logic [7:0]       s1;
    // u2: N=13, W=4, registered
    logic             v2 = 1'b0;
    logic [12:0][3:0] op2 = '0;
    logic             ov2;
    logic [7:0]       s2;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    gpc_sum_tree #(.N(8), .W(8), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v0), .operands(op0), .out_valid(ov0), .sum(s0));
    gpc_sum_tree #(.N(3), .W(6), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .operands(op1), .out_valid(ov1), .sum(s1));
    gpc_sum_tree #(.N(13), .W(4), .OUT_REG(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .operands(op2), .out_valid(ov2), .sum(s2));

    // {eight packed operands, expected total}
    localparam logic [74:0] VEC [8] = '{
        {64'h0000000000000000, 11'd0},
        {64'hFFFFFFFFFFFFFFFF, 11'd2040},
        {64'h0807060504030201, 11'd36},
        {64'h8080808080808080, 11'd1024},
        {64'h0F0F0F0F0F0F0F0F, 11'd120},
        {64'hFF00FF00FF00FF00, 11'd1020},
        {64'h0102040810204080, 11'd255},
        {64'hAA55AA55AA55AA55, 11'd1020}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tot0(input logic [7:0][7:0] o);
        int t = 0;
        for (int k = 0; k < 8; k++) t += int'(o[k]);
        return t;
    endfunction

    function automatic int tot1(input logic [2:0][5:0] o);
        int t = 0;
        for (int k = 0; k < 3; k++) t += int'(o[k]);
        return t;
    endfunction

    function automatic int tot2(input logic [12:0][3:0] o);
        int t = 0;
        for (int k = 0; k < 13; k++) t += int'(o[k]);
        return t;
    endfunction

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int last0;
        int e;
        // Reset wins over a pending request (R6)
        op0 = '1; v0 = 1'b1; op2 = '1; v2 = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 u0 sum in reset", int'(s0), 0);
        check("R6 u0 out_valid in reset", int'(ov0), 0);
        check("R6 u2 sum in reset", int'(s2), 0);
        check("R6 u2 out_valid in reset", int'(ov2), 0);
        v0 = 1'b0; v2 = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        last0 = 0;

        // Table walk on u0 (R1, R4)
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            op0 = VEC[i][74:11];
            v0  = 1'b1;
            #1;
            check("R4 u0 sum before edge", int'(s0), last0);
            @(posedge clk);
            #1;
            check("R1 u0 table sum", int'(s0), int'(VEC[i][10:0]));
            check("R4 u0 out_valid", int'(ov0), 1);
            last0 = int'(VEC[i][10:0]);
        end

        // Hold with in_valid low (R5, R4)
        @(negedge clk);
        v0  = 1'b0;
        op0 = 64'h1234567890ABCDEF;
        @(posedge clk);
        #1;
        check("R5 u0 sum held", int'(s0), last0);
        check("R4 u0 out_valid low", int'(ov0), 0);

        // Random operands on u0 (R1, R2)
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            op0 = {$urandom, $urandom};
            v0  = 1'b1;
            e   = tot0(op0);
            @(posedge clk);
            #1;
            check("R2 u0 random sum", int'(s0), e);
        end
        @(negedge clk);
        v0 = 1'b0;

        // N = 3, combinational (R3, R7)
        op1 = '1; v1 = 1'b1;
        #1;
        check("R3 u1 all ones", int'(s1), 189);
        check("R7 u1 out_valid follows", int'(ov1), 1);
        op1 = '0; v1 = 1'b0;
        #1;
        check("R3 u1 zero", int'(s1), 0);
        check("R7 u1 out_valid low", int'(ov1), 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            op1 = 18'($urandom);
            v1  = 1'($urandom);
            #1;
            check("R7 u1 random sum", int'(s1), tot1(op1));
            check("R7 u1 random valid", int'(ov1), int'(v1));
        end

        // N = 13, several levels (R2, R1)
        @(negedge clk);
        op2 = '1; v2 = 1'b1;
        @(posedge clk);
        #1;
        check("R1 u2 all ones", int'(s2), 195);
        check("R4 u2 out_valid", int'(ov2), 1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            op2 = 52'({$urandom, $urandom});
            v2  = 1'b1;
            e   = tot2(op2);
            @(posedge clk);
            #1;
            check("R2 u2 random sum", int'(s2), e);
        end
        @(negedge clk);
        v2  = 1'b0;
        op2 = '0;
        @(posedge clk);
        #1;
        check("R5 u2 sum held", int'(s2), e);

        // Reset again mid-run (R6)
        @(negedge clk);
        rst_n = 1'b0;
        v0 = 1'b1;
        @(posedge clk);
        #1;
        check("R6 u0 sum after reset", int'(s0), 0);
        check("R6 u0 valid after reset", int'(ov0), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule